// File: doc/BRIEF.md
# Read-Allocate Data Cache Controller

This block is a small level-one data cache placed between a CPU load/store port and a downstream memory request port that stands for the external memory path. Only read misses allocate lines. Loads that hit answer in the cycle of the request. Cacheable load misses fetch the whole line with one burst, then answer. Stores that hit change the cached line in place and mark it dirty. Stores that miss never allocate: they go into a small write buffer, and the buffer drains to the downstream port in arrival order.

A region register holds one bit per 16 MB address region and is cleared at reset, so every address starts out uncached. An uncached load becomes a single-word downstream read, and the CPU waits for it. The CPU sees the same handshake whether or not caching is on; only the number of wait cycles changes. Before any downstream read, the write buffer is emptied, so a read never overtakes an earlier write. A dirty line that a load miss must replace is written back word by word before the refill.

Top module: `rdalloc_dcache`

## Requirements
- R1: After reset all lines are invalid, every region bit is 0, the write buffer is empty, and no downstream request is raised until the CPU makes an access.
- R2: A load to a region whose bit is 0 issues one single-word downstream read (mem_burst=0). The CPU stalls until the data beat arrives and then receives that word. Repeating the load goes downstream again.
- R3: Region bit k governs the addresses whose bits [REGION_LSB +: log2(NUM_REGIONS)] equal k. A cfg_we pulse loads all bits from cfg_wdata at once.
- R4: A load miss in an enabled region issues one burst read (mem_burst=1) at the line base. It writes all LINE_WORDS beats into the line, marks the line valid, and then returns the requested word.
- R5: A load that hits a valid line of an enabled region raises cpu_ready in the same cycle as the request, with the word on cpu_rdata, and causes no downstream traffic.
- R6: A store that hits writes only the bytes whose cpu_be bit is set (bit i covers data bits 8i+7..8i). It completes in the same cycle and causes no downstream traffic at that time.
- R7: A store that misses never allocates a line. It enters a WB_DEPTH-entry FIFO and completes in the same cycle unless the FIFO is full, in which case the CPU stalls until an entry drains. Entries leave in order as single writes that carry their byte enables.
- R8: No downstream read is issued while the write buffer holds an entry, so a load sees every earlier store.
- R9: When a load miss replaces a valid dirty line, that line is first written back as LINE_WORDS single writes with all byte enables set. A clean victim is dropped without any write.
- R10: The cache is direct mapped. The line index is the address bits just above the word offset, and the tag is all bits above the index.
- R11: The CPU handshake is the same for cached and uncached accesses. cpu_req and the request fields are held until a cycle with cpu_ready=1, and cpu_rdata is valid in that cycle.
- R12: A downstream request holds its address and direction until mem_ack. Read beats arrive on mem_rvalid no earlier than the cycle after the ack, in ascending word order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Load the region register |
| cfg_wdata | input | NUM_REGIONS | New region enable bits |
| cpu_req | input | 1 | CPU access request, held until cpu_ready |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Byte address |
| cpu_wdata | input | DATA_W | Store data |
| cpu_be | input | DATA_W/8 | Store byte enables |
| cpu_ready | output | 1 | Access completes this cycle |
| cpu_rdata | output | DATA_W | Load data, valid with cpu_ready |
| mem_req | output | 1 | Downstream request |
| mem_we | output | 1 | Downstream write |
| mem_burst | output | 1 | Whole-line read |
| mem_addr | output | ADDR_W | Downstream address |
| mem_wdata | output | DATA_W | Downstream write data |
| mem_be | output | DATA_W/8 | Downstream byte enables |
| mem_ack | input | 1 | Request accepted; a write is complete |
| mem_rvalid | input | 1 | Read beat valid |
| mem_rdata | input | DATA_W | Read beat data |

## Verification
The bench builds the block with 8 lines of 8 words, 4 regions and a 4-entry buffer. With only 8 lines, every line can be filled and then every word swept for hits, and conflicting tags are easy to reach with addresses 1 KB apart, which exercises clean and dirty replacement. The 4-entry buffer can be filled completely by holding back the downstream acknowledge, so the full-buffer stall, write order and byte-enable merging on one address can all be observed. Two enabled regions next to disabled ones show that the region index decodes correctly.

// File: rtl/rdc_pkg.sv
package rdc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_DRAIN, ST_EVICT, ST_FILL_REQ,
    ST_FILL_WAIT, ST_UNC_REQ, ST_UNC_WAIT, ST_RESP
  } rdc_state_e;
endpackage

// File: rtl/rdc_region.sv
module rdc_region #(
  parameter int NUM_REGIONS = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_we,
  input  logic [NUM_REGIONS-1:0] cfg_wdata,
  output logic [NUM_REGIONS-1:0] region_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      region_q <= '0;
    else if (cfg_we) region_q <= cfg_wdata;
  end
endmodule

// File: rtl/rdc_wbuf.sv
module rdc_wbuf #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int DEPTH = 4,
  localparam int BW   = DW / 8,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [AW-1:0] push_addr,
  input  logic [DW-1:0] push_data,
  input  logic [BW-1:0] push_be,
  input  logic          pop,
  output logic [AW-1:0] head_addr,
  output logic [DW-1:0] head_data,
  output logic [BW-1:0] head_be,
  output logic          full,
  output logic          empty,
  output logic [CW-1:0] count
);
  logic [AW-1:0] addr_q [DEPTH];
  logic [DW-1:0] data_q [DEPTH];
  logic [BW-1:0] be_q   [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;

  function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full      = (count == CW'(DEPTH));
  assign empty     = (count == '0);
  assign head_addr = addr_q[rd_ptr];
  assign head_data = data_q[rd_ptr];
  assign head_be   = be_q[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) begin
      addr_q[wr_ptr] <= push_addr;
      data_q[wr_ptr] <= push_data;
      be_q[wr_ptr]   <= push_be;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= ptr_next(wr_ptr);
      if (pop)  rd_ptr <= ptr_next(rd_ptr);
      if (push && !pop)      count <= count + 1'b1;
      else if (pop && !push) count <= count - 1'b1;
    end
  end
endmodule

// File: rtl/rdc_array.sv
module rdc_array #(
  parameter int LINES  = 64,
  parameter int WORDS  = 8,
  parameter int TAG_W  = 21,
  parameter int DW     = 32,
  localparam int BW    = DW / 8,
  localparam int IDX_W = $clog2(LINES),
  localparam int WO_W  = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] a_idx,
  input  logic [WO_W-1:0]  a_woff,
  output logic [DW-1:0]    rd_word,
  output logic [TAG_W-1:0] lk_tag,
  output logic             lk_valid,
  output logic             lk_dirty,
  input  logic             wr_en,
  input  logic [DW-1:0]    wr_data,
  input  logic [BW-1:0]    wr_be,
  input  logic             wr_mark_dirty,
  input  logic             inst_en,
  input  logic [TAG_W-1:0] inst_tag
);
  logic [DW-1:0]    data_q  [LINES*WORDS];
  logic [TAG_W-1:0] tag_q   [LINES];
  logic [LINES-1:0] valid_q;
  logic [LINES-1:0] dirty_q;
  logic [IDX_W+WO_W-1:0] word_sel;

  assign word_sel = {a_idx, a_woff};
  assign rd_word  = data_q[word_sel];
  assign lk_tag   = tag_q[a_idx];
  assign lk_valid = valid_q[a_idx];
  assign lk_dirty = dirty_q[a_idx];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int b = 0; b < BW; b++)
        if (wr_be[b]) data_q[word_sel][b*8 +: 8] <= wr_data[b*8 +: 8];
    end
    if (inst_en) tag_q[a_idx] <= inst_tag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else begin
      if (inst_en) begin
        valid_q[a_idx] <= 1'b1;
        dirty_q[a_idx] <= 1'b0;
      end else if (wr_en && wr_mark_dirty) begin
        dirty_q[a_idx] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/rdalloc_dcache.sv
module rdalloc_dcache
  import rdc_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int LINE_WORDS  = 8,
  parameter int NUM_LINES   = 64,
  parameter int WB_DEPTH    = 4,
  parameter int NUM_REGIONS = 16,
  parameter int REGION_LSB  = 24
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_we,
  input  logic [NUM_REGIONS-1:0] cfg_wdata,
  input  logic                   cpu_req,
  input  logic                   cpu_we,
  input  logic [ADDR_W-1:0]      cpu_addr,
  input  logic [DATA_W-1:0]      cpu_wdata,
  input  logic [DATA_W/8-1:0]    cpu_be,
  output logic                   cpu_ready,
  output logic [DATA_W-1:0]      cpu_rdata,
  output logic                   mem_req,
  output logic                   mem_we,
  output logic                   mem_burst,
  output logic [ADDR_W-1:0]      mem_addr,
  output logic [DATA_W-1:0]      mem_wdata,
  output logic [DATA_W/8-1:0]    mem_be,
  input  logic                   mem_ack,
  input  logic                   mem_rvalid,
  input  logic [DATA_W-1:0]      mem_rdata
);
  localparam int BE_W   = DATA_W / 8;
  localparam int BOFF_W = $clog2(BE_W);
  localparam int WOFF_W = $clog2(LINE_WORDS);
  localparam int IDX_W  = $clog2(NUM_LINES);
  localparam int TAG_W  = ADDR_W - IDX_W - WOFF_W - BOFF_W;
  localparam int RIDX_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1;
  localparam int WBC_W  = $clog2(WB_DEPTH + 1);

  // address arithmetic
  function automatic logic [IDX_W-1:0] f_idx(input logic [ADDR_W-1:0] a);
    return a[BOFF_W+WOFF_W +: IDX_W];
  endfunction
  function automatic logic [TAG_W-1:0] f_tag(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction
  function automatic logic [WOFF_W-1:0] f_woff(input logic [ADDR_W-1:0] a);
    return a[BOFF_W +: WOFF_W];
  endfunction
  function automatic logic [RIDX_W-1:0] f_region(input logic [ADDR_W-1:0] a);
    return a[REGION_LSB +: RIDX_W];
  endfunction
  function automatic logic [ADDR_W-1:0] f_word_addr(input logic [TAG_W-1:0] t,
      input logic [IDX_W-1:0] i, input logic [WOFF_W-1:0] w);
    return {t, i, w, {BOFF_W{1'b0}}};
  endfunction

  rdc_state_e state;
  logic [ADDR_W-1:0] lm_addr;
  logic              lm_cach;
  logic [WOFF_W-1:0] cnt;
  logic [DATA_W-1:0] resp_q;

  logic [NUM_REGIONS-1:0] region_q;
  logic [IDX_W-1:0]  a_idx;
  logic [WOFF_W-1:0] a_woff;
  logic [DATA_W-1:0] rd_word;
  logic [TAG_W-1:0]  lk_tag;
  logic              lk_valid, lk_dirty;
  logic              arr_we, arr_dirty, inst_en;
  logic [DATA_W-1:0] arr_wdata;
  logic [BE_W-1:0]   arr_be;

  logic              wb_push, wb_pop, wb_full, wb_empty;
  logic [ADDR_W-1:0] wb_addr;
  logic [DATA_W-1:0] wb_data;
  logic [BE_W-1:0]   wb_be;
  logic [WBC_W-1:0]  wb_count;

  // named events for the checker
  logic fsm_idle, hit, ld_hit_ev, ld_miss_ev, st_hit_ev, st_miss_ev, last_word;

  rdc_region #(.NUM_REGIONS(NUM_REGIONS)) u_region (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .region_q(region_q)
  );

  rdc_array #(.LINES(NUM_LINES), .WORDS(LINE_WORDS), .TAG_W(TAG_W), .DW(DATA_W)) u_array (
    .clk(clk), .rst_n(rst_n), .a_idx(a_idx), .a_woff(a_woff),
    .rd_word(rd_word), .lk_tag(lk_tag), .lk_valid(lk_valid), .lk_dirty(lk_dirty),
    .wr_en(arr_we), .wr_data(arr_wdata), .wr_be(arr_be), .wr_mark_dirty(arr_dirty),
    .inst_en(inst_en), .inst_tag(f_tag(lm_addr))
  );

  rdc_wbuf #(.AW(ADDR_W), .DW(DATA_W), .DEPTH(WB_DEPTH)) u_wbuf (
    .clk(clk), .rst_n(rst_n),
    .push(wb_push), .push_addr(cpu_addr), .push_data(cpu_wdata), .push_be(cpu_be),
    .pop(wb_pop), .head_addr(wb_addr), .head_data(wb_data), .head_be(wb_be),
    .full(wb_full), .empty(wb_empty), .count(wb_count)
  );

  assign fsm_idle   = (state == ST_IDLE);
  assign a_idx      = fsm_idle ? f_idx(cpu_addr)  : f_idx(lm_addr);
  assign a_woff     = fsm_idle ? f_woff(cpu_addr) : cnt;
  assign hit        = lk_valid && (lk_tag == f_tag(cpu_addr)) && region_q[f_region(cpu_addr)];
  assign ld_hit_ev  = fsm_idle && cpu_req && !cpu_we && hit;
  assign ld_miss_ev = fsm_idle && cpu_req && !cpu_we && !hit;
  assign st_hit_ev  = fsm_idle && cpu_req && cpu_we && hit;
  assign st_miss_ev = fsm_idle && cpu_req && cpu_we && !hit;
  assign wb_push    = st_miss_ev && !wb_full;
  assign last_word  = (cnt == WOFF_W'(LINE_WORDS - 1));

  assign cpu_ready = ld_hit_ev || st_hit_ev || wb_push || (state == ST_RESP);
  assign cpu_rdata = (state == ST_RESP) ? resp_q : rd_word;

  // array write port: store hits in idle, refill beats otherwise
  assign arr_we    = st_hit_ev || ((state == ST_FILL_WAIT) && mem_rvalid);
  assign arr_wdata = fsm_idle ? cpu_wdata : mem_rdata;
  assign arr_be    = fsm_idle ? cpu_be : {BE_W{1'b1}};
  assign arr_dirty = fsm_idle;
  assign inst_en   = (state == ST_FILL_WAIT) && mem_rvalid && last_word;

  // downstream request mux
  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_burst = 1'b0;
    mem_addr  = wb_addr;
    mem_wdata = wb_data;
    mem_be    = wb_be;
    unique case (state)
      ST_IDLE, ST_DRAIN: begin
        mem_req = !wb_empty;
        mem_we  = 1'b1;
      end
      ST_EVICT: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = f_word_addr(lk_tag, f_idx(lm_addr), cnt);
        mem_wdata = rd_word;
        mem_be    = {BE_W{1'b1}};
      end
      ST_FILL_REQ: begin
        mem_req   = 1'b1;
        mem_burst = 1'b1;
        mem_addr  = f_word_addr(f_tag(lm_addr), f_idx(lm_addr), '0);
      end
      ST_UNC_REQ: begin
        mem_req  = 1'b1;
        mem_addr = lm_addr;
      end
      default: ;
    endcase
  end

  assign wb_pop = (fsm_idle || (state == ST_DRAIN)) && !wb_empty && mem_ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      lm_addr <= '0;
      lm_cach <= 1'b0;
      cnt     <= '0;
      resp_q  <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (ld_miss_ev) begin
          lm_addr <= cpu_addr;
          lm_cach <= region_q[f_region(cpu_addr)];
          state   <= ST_DRAIN;
        end
        ST_DRAIN: if (wb_empty) begin
          cnt <= '0;
          if (!lm_cach)               state <= ST_UNC_REQ;
          else if (lk_valid && lk_dirty) state <= ST_EVICT;
          else                        state <= ST_FILL_REQ;
        end
        ST_EVICT: if (mem_ack) begin
          cnt <= cnt + 1'b1;
          if (last_word) state <= ST_FILL_REQ;
        end
        ST_FILL_REQ: if (mem_ack) begin
          cnt   <= '0;
          state <= ST_FILL_WAIT;
        end
        ST_FILL_WAIT: if (mem_rvalid) begin
          cnt <= cnt + 1'b1;
          if (cnt == f_woff(lm_addr)) resp_q <= mem_rdata;
          if (last_word) state <= ST_RESP;
        end
        ST_UNC_REQ: if (mem_ack) state <= ST_UNC_WAIT;
        ST_UNC_WAIT: if (mem_rvalid) begin
          resp_q <= mem_rdata;
          state  <= ST_RESP;
        end
        ST_RESP: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rdc_checker.sv
module rdc_checker #(
  parameter int ADDR_W      = 32,
  parameter int NUM_REGIONS = 16,
  parameter int REGION_LSB  = 24,
  parameter int WBC_W       = 3,
  localparam int RIDX_W     = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   cpu_req,
  input logic                   cpu_we,
  input logic                   cpu_ready,
  input logic                   fsm_idle,
  input logic                   hit,
  input logic                   wb_full,
  input logic                   wb_empty,
  input logic [WBC_W-1:0]       wb_count,
  input logic                   st_hit_ev,
  input logic [NUM_REGIONS-1:0] region_q,
  input logic                   mem_req,
  input logic                   mem_we,
  input logic                   mem_burst,
  input logic [ADDR_W-1:0]      mem_addr,
  input logic                   mem_ack
);
  logic [RIDX_W-1:0] req_region;
  assign req_region = mem_addr[REGION_LSB +: RIDX_W];

  AST_READ_AFTER_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |-> wb_empty); // R8

  AST_FULL_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    (fsm_idle && cpu_req && cpu_we && !hit && wb_full) |-> !cpu_ready); // R7

  AST_HIT_NO_QUEUE: assert property (@(posedge clk) disable iff (!rst_n)
    st_hit_ev |=> (wb_count <= $past(wb_count))); // R6

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R12

  AST_READ_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |-> (mem_burst == region_q[req_region])); // R2
endmodule

bind rdalloc_dcache rdc_checker #(
  .ADDR_W(ADDR_W), .NUM_REGIONS(NUM_REGIONS), .REGION_LSB(REGION_LSB), .WBC_W(WBC_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_ready(cpu_ready),
  .fsm_idle(fsm_idle), .hit(hit), .wb_full(wb_full), .wb_empty(wb_empty),
  .wb_count(wb_count), .st_hit_ev(st_hit_ev), .region_q(region_q),
  .mem_req(mem_req), .mem_we(mem_we), .mem_burst(mem_burst), .mem_addr(mem_addr),
  .mem_ack(mem_ack)
);

// File: tb/tb_rdalloc_dcache.sv
module tb_rdalloc_dcache;
  localparam int CLK_PERIOD = 10;
  localparam int NREG = 4;
  localparam int MW   = 2048;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0;
  logic [NREG-1:0] cfg_wdata = '0;
  logic cpu_req = 0, cpu_we = 0;
  logic [31:0] cpu_addr = '0, cpu_wdata = '0;
  logic [3:0] cpu_be = '0;
  logic cpu_ready;
  logic [31:0] cpu_rdata;
  logic mem_req, mem_we, mem_burst;
  logic [31:0] mem_addr, mem_wdata;
  logic [3:0] mem_be;
  logic mem_ack = 0, mem_rvalid = 0;
  logic [31:0] mem_rdata = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rdalloc_dcache #(.LINE_WORDS(8), .NUM_LINES(8), .WB_DEPTH(4), .NUM_REGIONS(NREG),
                   .REGION_LSB(24)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_be(cpu_be), .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_burst(mem_burst), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_ack(mem_ack),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  int n_chk = 0, n_err = 0, stab_err = 0;
  int n_rd = 0, n_wr = 0, beats = 0;
  logic last_burst = 0, hold_ack = 0, done = 0;
  logic [31:0] raddr = '0;
  logic [31:0] mem  [MW];
  logic [31:0] gold [MW];

  function automatic int midx(input logic [31:0] a);
    return int'({a[24], a[11:2]});
  endfunction
  function automatic logic [31:0] init_word(input int i);
    return (i * 32'h9E3779B1) ^ 32'h5A5A0000;
  endfunction
  function automatic logic [31:0] merge(input logic [31:0] old, nw, input logic [3:0] be);
    logic [31:0] r = old;
    for (int b = 0; b < 4; b++) if (be[b]) r[b*8 +: 8] = nw[b*8 +: 8];
    return r;
  endfunction

  // downstream memory model: registered ack, one beat per cycle after the ack
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < MW; i++) mem[i] <= init_word(i);
      mem_ack <= 0; mem_rvalid <= 0; beats <= 0;
    end else begin
      mem_ack <= mem_req && !mem_ack && !hold_ack && (beats == 0);
      if (mem_req && mem_ack) begin
        if (mem_we) begin
          mem[midx(mem_addr)] <= merge(mem[midx(mem_addr)], mem_wdata, mem_be);
          n_wr <= n_wr + 1;
        end else begin
          beats <= mem_burst ? 8 : 1;
          raddr <= mem_addr;
          last_burst <= mem_burst;
          n_rd <= n_rd + 1;
        end
      end
      if (beats > 0) begin
        mem_rvalid <= 1; mem_rdata <= mem[midx(raddr)];
        raddr <= raddr + 4; beats <= beats - 1;
      end else mem_rvalid <= 0;
    end
  end

  // R12 monitor: a pending request keeps address and direction
  logic p_pend = 0, p_we = 0;
  logic [31:0] p_addr = '0;
  always @(negedge clk) begin
    if (rst_n && p_pend && !(mem_req && mem_addr == p_addr && mem_we == p_we)) stab_err++;
    p_pend = mem_req && !mem_ack;
    p_addr = mem_addr; p_we = mem_we;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cpu_op(input logic we, input logic [31:0] a, d, input logic [3:0] be,
                        output logic [31:0] rd, output int cyc);
    @(negedge clk);
    cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = d; cpu_be = be; cyc = 0;
    #1;
    while (!cpu_ready) begin @(negedge clk); #1; cyc++; end
    rd = cpu_rdata;
    if (we) gold[midx(a)] = merge(gold[midx(a)], d, be);
    @(posedge clk); #1;
    cpu_req = 0; cpu_we = 0;
  endtask

  task automatic set_regions(input logic [NREG-1:0] v);
    @(negedge clk); cfg_we = 1; cfg_wdata = v;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic load_chk(input logic [31:0] a, input string req, output int cyc);
    logic [31:0] rd;
    cpu_op(0, a, 0, 0, rd, cyc);
    chk(rd == gold[midx(a)], req, rd, gold[midx(a)]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd, a;
    int cyc, r0, w0;
    for (int i = 0; i < MW; i++) gold[i] = init_word(i);
    repeat (3) @(posedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk(mem_req == 0 && cpu_ready == 0, "R1 idle after reset", {mem_req, cpu_ready}, 0);

    // R1/R2: regions off at reset, every load goes downstream as one word
    r0 = n_rd;
    load_chk(32'h0100_0020, "R2 uncached data", cyc);
    chk(cyc > 0 && last_burst == 0 && n_rd == r0 + 1, "R1 R2 single read", n_rd - r0, 1);
    load_chk(32'h0100_0020, "R2 repeat data", cyc);
    chk(n_rd == r0 + 2 && last_burst == 0, "R2 repeat goes downstream", n_rd - r0, 2);

    // R3: enable region 1 only; region 0 stays uncached
    set_regions(4'b0010);
    load_chk(32'h0000_0040, "R3 region0 data", cyc);
    chk(last_burst == 0, "R3 region0 uncached", last_burst, 0);

    // R4: fill every line of the small cache
    for (int l = 0; l < 8; l++) begin
      r0 = n_rd;
      a = 32'h0100_0000 + l * 32 + 4 * ((l * 3) % 8);
      load_chk(a, "R4 fill word", cyc);
      chk(n_rd == r0 + 1 && last_burst == 1 && cyc > 8, "R4 one burst", n_rd - r0, 1);
    end

    // R5/R12: every word of every line now hits in the request cycle
    r0 = n_rd;
    for (int l = 0; l < 8; l++)
      for (int w = 0; w < 8; w++) begin
        load_chk(32'h0100_0000 + l * 32 + w * 4, "R5 R12 hit word", cyc);
        chk(cyc == 0, "R5 hit latency", cyc, 0);
      end
    chk(n_rd == r0, "R5 no downstream reads", n_rd - r0, 0);

    // R6: store hit merges bytes, no traffic
    w0 = n_wr;
    cpu_op(1, 32'h0100_0044, 32'hDEAD_BEEF, 4'b0101, rd, cyc);
    chk(cyc == 0, "R6 store hit latency", cyc, 0);
    repeat (6) @(negedge clk);
    chk(n_wr == w0 && mem_req == 0, "R6 no traffic", n_wr - w0, 0);
    load_chk(32'h0100_0044, "R6 merged bytes", cyc);
    chk(cyc == 0, "R6 still a hit", cyc, 0);

    // R9/R10: conflicting tag on index 2 evicts the dirty line
    w0 = n_wr; r0 = n_rd;
    load_chk(32'h0100_0444, "R10 conflict data", cyc);
    chk(n_wr == w0 + 8, "R9 dirty writeback count", n_wr - w0, 8);
    chk(n_rd == r0 + 1 && last_burst == 1, "R10 conflict refill", n_rd - r0, 1);
    chk(mem[midx(32'h0100_0044)] == gold[midx(32'h0100_0044)], "R9 written back data",
        mem[midx(32'h0100_0044)], gold[midx(32'h0100_0044)]);
    w0 = n_wr;
    load_chk(32'h0100_0044, "R9 reload data", cyc);
    chk(cyc > 0 && n_wr == w0, "R9 clean victim dropped", n_wr - w0, 0);
    w0 = n_wr;
    load_chk(32'h0100_0460, "R10 index3 conflict", cyc);
    chk(n_wr == w0, "R9 clean index3 victim", n_wr - w0, 0);

    // R7/R8: store miss does not allocate; load after it sees the data
    cpu_op(1, 32'h0100_0800, 32'h1234_5678, 4'b1111, rd, cyc);
    chk(cyc == 0, "R7 store miss accepted", cyc, 0);
    r0 = n_rd;
    load_chk(32'h0100_0800, "R8 load sees store", cyc);
    chk(cyc > 0 && n_rd == r0 + 1, "R7 no allocate on store", n_rd - r0, 1);

    // R7: fill buffer with acks held back, fifth store stalls
    hold_ack = 1;
    cpu_op(1, 32'h0000_0100, 32'hAAAA_0001, 4'b1111, rd, cyc); chk(cyc == 0, "R7 push1", cyc, 0);
    cpu_op(1, 32'h0000_0104, 32'hBBBB_0002, 4'b0011, rd, cyc); chk(cyc == 0, "R7 push2", cyc, 0);
    cpu_op(1, 32'h0000_0108, 32'hCCCC_0003, 4'b1000, rd, cyc); chk(cyc == 0, "R7 push3", cyc, 0);
    cpu_op(1, 32'h0000_010C, 32'hDDDD_0004, 4'b1111, rd, cyc); chk(cyc == 0, "R7 push4", cyc, 0);
    fork
      begin repeat (20) @(negedge clk); hold_ack = 0; end
    join_none
    cpu_op(1, 32'h0000_0100, 32'h5555_5555, 4'b0110, rd, cyc);
    chk(cyc >= 19, "R7 full buffer stalls", cyc, 19);
    for (int k = 0; k < 4; k++) load_chk(32'h0000_0100 + 4 * k, "R7 R8 ordered bytes", cyc);

    // R11/R3: same word, uncached then cached, same data
    load_chk(32'h0000_0200, "R11 uncached", cyc);
    chk(last_burst == 0, "R11 uncached kind", last_burst, 0);
    set_regions(4'b0011);
    load_chk(32'h0000_0200, "R11 cached miss", cyc);
    chk(cyc > 0 && last_burst == 1, "R3 region0 now cacheable", last_burst, 1);
    load_chk(32'h0000_0200, "R11 cached hit", cyc);
    chk(cyc == 0, "R11 hit latency", cyc, 0);
    load_chk(32'h0200_0300, "R3 region2 data", cyc);
    chk(last_burst == 0, "R3 region2 uncached", last_burst, 0);

    chk(stab_err == 0, "R12 request held until ack", stab_err, 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule